// File: doc/BRIEF.md
# SPI Flash Atomic Command Sequencer

This block runs one software-built command cycle against a serial flash device. A host loads a command word, an address and up to 64 data bytes through a small register and buffer interface, then pulses a start strobe. The engine shifts the command out on a single-bit SPI link in mode 0: clock idles low, the device samples on rising edges, and read data is captured on rising edges.

When a cycle is marked atomic, the command is wrapped in a fixed sequence. First a one-byte prefix frame carries one of two stored prefix opcodes, typically write enable. Then the command frame is sent. Then status-read frames repeat until the device reports that it is not busy, or until a programmable poll limit runs out. Each frame has its own chip-select assertion. A sticky lock bit freezes the prefix pair and the opcode slots, so a cycle can only use opcodes that were set up before locking.

Host registers, selected by `reg_sel`: 0 = command word, 1 = address (low 24 bits), 2 = prefix pair (low 16 bits), 3 = opcode slots (byte n of the word is slot n), 4 = poll limit (low 16 bits). Command word fields: [6:0] data byte count minus one, [7] data enable, [8] address enable, [9] atomic, [10] prefix choice, [12:11] opcode slot, [13] read direction (1 = read into buffer), [31] lock.

Top module: `spi_atomic_seq`

## Requirements
- R1: In an atomic cycle the first frame is exactly one byte. That byte is prefix-pair bits 15:8 when command bit 10 is 1, and bits 7:0 when it is 0.
- R2: An atomic cycle sends the prefix frame, then the command frame, then two-byte status frames that start with 0x05. It stops after the first status byte whose bit 0 is 0. A non-atomic cycle sends only the command frame.
- R3: A start with data enabled and a count field above 63 sets `err_len` on the next clock. It causes no chip-select activity and no `cmd_done` pulse.
- R4: With data enabled, the command frame carries count field + 1 data bytes, so a field of 63 moves all 64 buffer bytes.
- R5: With data disabled the count field is ignored. The command frame is the slot opcode, plus the address if address is enabled.
- R6: The command frame opens with the opcode from the slot named by bits 12:11. When address is enabled, the 24-bit address follows, most significant byte first; otherwise no address is sent.
- R7: Writing 1 to command bit 31 sets a lock that holds until reset. While it is set, writes to the prefix pair and to the opcode slots have no effect.
- R8: If every status frame up to the poll limit reports busy, the cycle ends with `err_timeout` set, a `cmd_done` pulse and chip select released. No further frame is sent.
- R9: Between frames of a cycle, chip select stays high for at least two clocks (one SCLK period). SCLK is low whenever chip select is high.
- R10: `cmd_done` is high for exactly one clock at the end of a cycle. Error flags stay set until the next start strobe clears them.
- R11: Bytes go out MSB first. Write data comes from buffer index 0 upward. Read data is sampled on the rising SCLK edge and stored from buffer index 0 upward.
- R12: After reset, chip select is high, SCLK is low, and `cmd_busy`, `cmd_done`, `err_len` and `err_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| buf_wr | input | 1 | Host buffer write strobe |
| buf_widx | input | 6 | Host buffer write index |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_ridx | input | 6 | Host buffer read index |
| buf_rdata | output | 8 | Host buffer read byte |
| cmd_go | input | 1 | Start strobe |
| cmd_busy | output | 1 | Cycle in progress |
| cmd_done | output | 1 | One-clock end-of-cycle pulse |
| err_len | output | 1 | Length rejected |
| err_timeout | output | 1 | Busy poll limit reached |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bench targets several boundaries where a faulty engine gives a visibly wrong frame sequence.

- The prefix choice is run both ways. A swapped byte pick sends the volatile-status enable where plain write enable was wanted.
- A count field of 64 is rejected, while a field of 63 moves the full buffer. An off-by-one in the limit shows up either as a wire transfer that should not happen or as a refused full-buffer cycle.
- Polling is driven both through several busy replies and into an exhausted limit. A bad counter shows up as the wrong number of status frames or a missing timeout flag.
- After locking, new prefix and slot values are written and then checked on the wire. A lock that leaks would change the transmitted opcodes.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int CNT_W  = 7;
    localparam int SLOT_W = 2;
    localparam int MENU_W = 8 << SLOT_W;

    localparam logic [7:0] OP_RDSR = 8'h05;

    localparam logic [2:0] SEL_CTRL   = 3'd0;
    localparam logic [2:0] SEL_ADDR   = 3'd1;
    localparam logic [2:0] SEL_PREFIX = 3'd2;
    localparam logic [2:0] SEL_MENU   = 3'd3;
    localparam logic [2:0] SEL_POLL   = 3'd4;

    typedef struct packed {
        logic              lock;
        logic [16:0]       rsvd;
        logic              rd;
        logic [SLOT_W-1:0] slot;
        logic              pre_hi;
        logic              atomic;
        logic              addr_en;
        logic              data_en;
        logic [CNT_W-1:0]  cnt;
    } ctrl_t;

    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_GAP} st_t;
    typedef enum logic [1:0] {FR_PRE, FR_CMD, FR_POLL} fr_t;

    function automatic logic [7:0] pick_prefix(input logic [15:0] pair, input logic hi);
        return hi ? pair[15:8] : pair[7:0];
    endfunction

endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
    import spi_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [2:0]        sel,
    input  logic [31:0]       wdata,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] addr,
    output logic [15:0]       prefix,
    output logic [MENU_W-1:0] menu,
    output logic [POLL_W-1:0] poll_lim
);

    ctrl_t ctrl_next;

    always_comb begin
        ctrl_next      = ctrl_t'(wdata);
        ctrl_next.rsvd = '0;
        ctrl_next.lock = ctrl.lock | wdata[31];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            addr     <= '0;
            prefix   <= '0;
            menu     <= '0;
            poll_lim <= '1;
        end else if (wr) begin
            case (sel)
                SEL_CTRL:   ctrl     <= ctrl_next;
                SEL_ADDR:   addr     <= wdata[ADDR_W-1:0];
                SEL_PREFIX: if (!ctrl.lock) prefix <= wdata[15:0];
                SEL_MENU:   if (!ctrl.lock) menu   <= wdata[MENU_W-1:0];
                SEL_POLL:   poll_lim <= wdata[POLL_W-1:0];
                default:    ;
            endcase
        end
    end

    // R7
    prefix_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.lock && wr && sel == SEL_PREFIX) |=> $stable(prefix));
    // R7
    menu_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.lock && wr && sel == SEL_MENU) |=> $stable(menu));
    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.lock |=> ctrl.lock);

endmodule

// File: rtl/spi_seq_buf.sv
module spi_seq_buf #(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [7:0]    rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];

endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);

    logic       act;
    logic       ph;
    logic [2:0] cnt;
    logic [7:0] tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= 1'b0;
            ph      <= 1'b0;
            cnt     <= '0;
            tx      <= '0;
            rx_byte <= '0;
        end else if (start) begin
            act <= 1'b1;
            ph  <= 1'b0;
            cnt <= '0;
            tx  <= tx_byte;
        end else if (act) begin
            if (!ph) begin
                ph      <= 1'b1;
                rx_byte <= {rx_byte[6:0], miso};
            end else begin
                ph  <= 1'b0;
                tx  <= {tx[6:0], 1'b0};
                cnt <= cnt + 3'd1;
                if (cnt == 3'd7) act <= 1'b0;
            end
        end
    end

    assign sclk = act & ph;
    assign mosi = tx[7];
    assign done = act & ph & (cnt == 3'd7);

    // R11
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));
    // R11
    byte_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !sclk);

endmodule

// File: rtl/spi_atomic_seq.sv
module spi_atomic_seq
    import spi_seq_pkg::*;
#(
    parameter int BUF_DEPTH  = 64,
    parameter int ADDR_BYTES = 3,
    parameter int POLL_W     = 16,
    parameter int GAP_CLKS   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        buf_wr,
    input  logic [5:0]  buf_widx,
    input  logic [7:0]  buf_wdata,
    input  logic [5:0]  buf_ridx,
    output logic [7:0]  buf_rdata,
    input  logic        cmd_go,
    output logic        cmd_busy,
    output logic        cmd_done,
    output logic        err_len,
    output logic        err_timeout,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int BW     = $clog2(BUF_DEPTH);
    localparam int IDXW   = $clog2(BUF_DEPTH + ADDR_BYTES + 2);
    localparam int GW     = $clog2(GAP_CLKS + 1);
    localparam logic [CNT_W-1:0] MAXCNT = CNT_W'(BUF_DEPTH - 1);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] addr;
    logic [15:0]       prefix;
    logic [MENU_W-1:0] menu;
    logic [POLL_W-1:0] plim;

    st_t              state;
    fr_t              frame;
    logic [IDXW-1:0]  bidx;
    logic [POLL_W-1:0] pcnt;
    logic [POLL_W:0]  pnext;
    logic [GW-1:0]    gcnt;
    logic             done_q, elen_q, etmo_q;

    logic [IDXW-1:0]  hdr, flen;
    logic             last;
    logic [7:0]       tx;
    logic             sh_done;
    logic [7:0]       sh_rx;
    logic [BW-1:0]    didx;
    logic [7:0]       eng_rdata;
    logic             eng_we;
    logic             buf_we;
    logic [BW-1:0]    buf_wi;
    logic [7:0]       buf_wd;
    logic             unused_ok;

    assign unused_ok = ^{ctrl.rsvd, ctrl.lock};

    spi_seq_regs #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .ctrl(ctrl), .addr(addr), .prefix(prefix), .menu(menu), .poll_lim(plim)
    );

    // header and frame length of the current frame
    always_comb begin
        hdr = IDXW'(1) + (ctrl.addr_en ? IDXW'(ADDR_BYTES) : '0);
        case (frame)
            FR_PRE:  flen = IDXW'(1);
            FR_POLL: flen = IDXW'(2);
            default: flen = hdr + (ctrl.data_en ? (IDXW'(ctrl.cnt) + IDXW'(1)) : '0);
        endcase
    end

    assign last  = (bidx == flen - IDXW'(1));
    assign didx  = BW'(bidx - hdr);
    assign pnext = {1'b0, pcnt} + {{POLL_W{1'b0}}, 1'b1};

    // byte to shift next
    always_comb begin
        tx = 8'h00;
        case (frame)
            FR_PRE:  tx = pick_prefix(prefix, ctrl.pre_hi);
            FR_POLL: tx = (bidx == '0) ? OP_RDSR : 8'h00;
            default: begin
                if (bidx == '0) begin
                    tx = menu[{ctrl.slot, 3'b000} +: 8];
                end else if (bidx < hdr) begin
                    for (int i = 0; i < ADDR_BYTES; i++) begin
                        if (bidx == IDXW'(i + 1)) tx = addr[(ADDR_BYTES-1-i)*8 +: 8];
                    end
                end else if (!ctrl.rd) begin
                    tx = eng_rdata;
                end
            end
        endcase
    end

    spi_seq_shift u_shift (
        .clk(clk), .rst(rst), .start(state == S_LOAD), .tx_byte(tx),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .rx_byte(sh_rx), .done(sh_done)
    );

    assign eng_we = (state == S_SHIFT) && sh_done && (frame == FR_CMD) &&
                    ctrl.data_en && ctrl.rd && (bidx >= hdr);
    assign buf_we = eng_we | buf_wr;
    assign buf_wi = eng_we ? didx  : buf_widx;
    assign buf_wd = eng_we ? sh_rx : buf_wdata;

    spi_seq_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .we(buf_we), .widx(buf_wi), .wdata(buf_wd),
        .ridx_a(buf_ridx), .rdata_a(buf_rdata),
        .ridx_b(didx), .rdata_b(eng_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            frame  <= FR_CMD;
            bidx   <= '0;
            pcnt   <= '0;
            gcnt   <= '0;
            done_q <= 1'b0;
            elen_q <= 1'b0;
            etmo_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: if (cmd_go) begin
                    elen_q <= 1'b0;
                    etmo_q <= 1'b0;
                    bidx   <= '0;
                    pcnt   <= '0;
                    if (ctrl.data_en && ctrl.cnt > MAXCNT) begin
                        elen_q <= 1'b1;
                    end else begin
                        state <= S_LOAD;
                        frame <= ctrl.atomic ? FR_PRE : FR_CMD;
                    end
                end
                S_LOAD: state <= S_SHIFT;
                S_SHIFT: if (sh_done) begin
                    if (!last) begin
                        bidx  <= bidx + IDXW'(1);
                        state <= S_LOAD;
                    end else begin
                        bidx <= '0;
                        case (frame)
                            FR_PRE: begin
                                frame <= FR_CMD;
                                state <= S_GAP;
                            end
                            FR_CMD: if (ctrl.atomic) begin
                                frame <= FR_POLL;
                                state <= S_GAP;
                            end else begin
                                state  <= S_IDLE;
                                done_q <= 1'b1;
                            end
                            default: if (!sh_rx[0]) begin
                                state  <= S_IDLE;
                                done_q <= 1'b1;
                            end else if (pnext >= {1'b0, plim}) begin
                                etmo_q <= 1'b1;
                                state  <= S_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                pcnt  <= pnext[POLL_W-1:0];
                                state <= S_GAP;
                            end
                        endcase
                    end
                end
                S_GAP: if (gcnt == GW'(GAP_CLKS - 1)) begin
                    gcnt  <= '0;
                    state <= S_LOAD;
                end else begin
                    gcnt <= gcnt + GW'(1);
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign spi_cs_n    = !((state == S_LOAD) || (state == S_SHIFT));
    assign cmd_busy    = (state != S_IDLE);
    assign cmd_done    = done_q;
    assign err_len     = elen_q;
    assign err_timeout = etmo_q;

    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done);
    // R3
    len_reject_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_len) |-> (spi_cs_n && !cmd_busy && !cmd_done));
    // R8
    timeout_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_timeout) |-> (cmd_done && spi_cs_n));
    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_len && !cmd_go) |=> err_len);

endmodule

// File: tb/sim_spi_atomic_seq.sv
module sim_spi_atomic_seq;
    import spi_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        buf_wr = 1'b0;
    logic [5:0]  buf_widx = '0;
    logic [7:0]  buf_wdata = '0;
    logic [5:0]  buf_ridx = '0;
    logic [7:0]  buf_rdata;
    logic        cmd_go = 1'b0;
    logic        cmd_busy, cmd_done, err_len, err_timeout;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    always #5 clk = ~clk;

    spi_atomic_seq u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .buf_wr(buf_wr), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
        .buf_ridx(buf_ridx), .buf_rdata(buf_rdata), .cmd_go(cmd_go),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done), .err_len(err_len),
        .err_timeout(err_timeout), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int p);
        return 8'(p * 17) ^ 8'h5A;
    endfunction

    // ---- behavioural flash model: records frames, answers reads and status ----
    logic [7:0] fb [0:31][0:71];
    int   flen [0:31];
    int   nfr = 0;
    int   nb = 0;
    int   npoll = 0;
    int   busy_until = 0;
    logic [7:0] cur = '0;
    logic [7:0] txb = '0;
    logic prev_cs = 1'b1;
    logic prev_sclk = 1'b0;

    always @(spi_cs_n or spi_sclk) begin
        if (prev_cs === 1'b1 && spi_cs_n === 1'b0) begin
            nb = 0; cur = '0; txb = '0;
            spi_miso = txb[7];
            txb = {txb[6:0], 1'b0};
        end else if (prev_cs === 1'b0 && spi_cs_n === 1'b1) begin
            flen[nfr] = nb / 8;
            if (nfr < 31) nfr++;
        end else if (spi_cs_n === 1'b0 && prev_sclk === 1'b0 && spi_sclk === 1'b1) begin
            cur = {cur[6:0], spi_mosi};
            nb++;
            if (nb % 8 == 0 && nb / 8 <= 72) fb[nfr][nb/8 - 1] = cur;
        end else if (spi_cs_n === 1'b0 && prev_sclk === 1'b1 && spi_sclk === 1'b0) begin
            if (nb % 8 == 0) begin
                if (nb / 8 == 1 && fb[nfr][0] == 8'h05) begin
                    txb = (npoll < busy_until) ? 8'h01 : 8'h00;
                    npoll++;
                end else begin
                    txb = pat(nb / 8);
                end
            end
            spi_miso = txb[7];
            txb = {txb[6:0], 1'b0};
        end
        prev_cs = spi_cs_n;
        prev_sclk = spi_sclk;
    end

    // ---- per-clock protocol monitor ----
    int hi = 100;
    always @(negedge clk) begin
        if (!rst) begin
            if (spi_cs_n && spi_sclk) begin
                nerr++;
                $display("FAIL R9 sclk high while cs high: actual 1 expected 0");
            end
            if (spi_cs_n) hi++;
            else begin
                if (hi > 0) begin
                    nchk++;
                    if (hi < 2) begin
                        nerr++;
                        $display("FAIL R9 cs high gap: actual %0d expected >=2", hi);
                    end
                end
                hi = 0;
            end
        end
    end

    // ---- host tasks ----
    task automatic wreg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wbuf(input int i, input logic [7:0] d);
        @(negedge clk); buf_wr = 1'b1; buf_widx = 6'(i); buf_wdata = d;
        @(negedge clk); buf_wr = 1'b0;
    endtask

    function automatic logic [31:0] mk(input int cnt, input bit den, input bit aen,
            input bit atom, input bit phi, input int slot, input bit rd, input bit lk);
        return {lk, 17'b0, rd, 2'(slot), phi, atom, aen, den, 7'(cnt)};
    endfunction

    task automatic start(input logic [31:0] c);
        wreg(SEL_CTRL, c);
        @(negedge clk); cmd_go = 1'b1;
        @(negedge clk); cmd_go = 1'b0;
    endtask

    task automatic finish_wait(input string req);
        int n = 0;
        while (!cmd_done && n < 40000) begin
            @(negedge clk); n++;
        end
        check(cmd_done, req, "done seen", int'(cmd_done), 1);
        @(negedge clk);
        check(!cmd_done, "R10", "done one clock", int'(cmd_done), 0);
    endtask

    task automatic run(input logic [31:0] c, input string req);
        start(c);
        finish_wait(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(spi_cs_n == 1'b1, "R12", "cs_n", int'(spi_cs_n), 1);
        check(spi_sclk == 1'b0, "R12", "sclk", int'(spi_sclk), 0);
        check(!cmd_busy && !cmd_done, "R12", "busy/done", int'({cmd_busy, cmd_done}), 0);
        check(!err_len && !err_timeout, "R12", "errors", int'({err_len, err_timeout}), 0);

        wreg(SEL_PREFIX, 32'h0000_5006);
        wreg(SEL_MENU, {8'h9F, 8'h20, 8'h02, 8'h03});
        wreg(SEL_ADDR, 32'h0012_3456);
        wreg(SEL_POLL, 32'd8);

        // T1 non-atomic write with address, 4 bytes (R6 R11 R4 R2)
        for (int i = 0; i < 4; i++) wbuf(i, 8'(8'hC0 + i));
        b = nfr;
        run(mk(3, 1, 1, 0, 0, 1, 0, 0), "R2");
        check(nfr - b == 1, "R2", "non-atomic frame count", nfr - b, 1);
        check(flen[b] == 8, "R4", "write frame length", flen[b], 8);
        check(fb[b][0] == 8'h02, "R6", "slot opcode", int'(fb[b][0]), 8'h02);
        check(fb[b][1] == 8'h12 && fb[b][2] == 8'h34 && fb[b][3] == 8'h56, "R6",
              "address order", int'({fb[b][1], fb[b][2], fb[b][3]}), 24'h123456);
        for (int i = 0; i < 4; i++)
            check(fb[b][4+i] == 8'(8'hC0 + i), "R11", "write data order",
                  int'(fb[b][4+i]), 8'hC0 + i);

        // T2 atomic, low prefix, two busy polls (R1 R2 R5)
        busy_until = npoll + 2;
        b = nfr;
        run(mk(0, 0, 1, 1, 0, 2, 0, 0), "R2");
        check(nfr - b == 5, "R2", "atomic frame count", nfr - b, 5);
        check(flen[b] == 1 && fb[b][0] == 8'h06, "R1", "low prefix", int'(fb[b][0]), 8'h06);
        check(flen[b+1] == 4 && fb[b+1][0] == 8'h20, "R5", "cmd without data",
              flen[b+1], 4);
        for (int k = 2; k < 5; k++)
            check(flen[b+k] == 2 && fb[b+k][0] == 8'h05, "R2", "poll frame",
                  int'(fb[b+k][0]), 8'h05);
        check(!err_timeout, "R2", "no timeout", int'(err_timeout), 0);

        // T3 atomic, high prefix, device ready (R1)
        busy_until = npoll;
        b = nfr;
        run(mk(0, 0, 0, 1, 1, 3, 0, 0), "R1");
        check(nfr - b == 3, "R2", "ready frame count", nfr - b, 3);
        check(fb[b][0] == 8'h50, "R1", "high prefix", int'(fb[b][0]), 8'h50);
        check(flen[b+1] == 1 && fb[b+1][0] == 8'h9F, "R6", "no address", flen[b+1], 1);

        // T4 read 5 bytes with address (R11 R4)
        b = nfr;
        run(mk(4, 1, 1, 0, 0, 0, 1, 0), "R11");
        check(flen[b] == 9 && fb[b][0] == 8'h03, "R4", "read frame length", flen[b], 9);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); buf_ridx = 6'(k); #1;
            check(buf_rdata == pat(4 + k), "R11", "read byte", int'(buf_rdata),
                  int'(pat(4 + k)));
        end

        // T5 data disabled, count ignored (R5)
        b = nfr;
        run(mk(5, 0, 0, 0, 0, 3, 0, 0), "R5");
        check(flen[b] == 1 && fb[b][0] == 8'h9F, "R5", "opcode only", flen[b], 1);

        // T6 length reject and boundary (R3 R4 R10)
        for (int i = 0; i < 64; i++) wbuf(i, 8'(i) ^ 8'h3C);
        b = nfr;
        start(mk(64, 1, 0, 0, 0, 1, 0, 0));
        check(err_len == 1'b1, "R3", "err_len", int'(err_len), 1);
        repeat (40) begin
            @(negedge clk);
            if (!spi_cs_n || cmd_done || cmd_busy) begin
                check(0, "R3", "no activity", int'({spi_cs_n, cmd_done, cmd_busy}), 4);
            end
        end
        check(nfr == b, "R3", "no frame", nfr - b, 0);
        check(err_len == 1'b1, "R10", "err_len held", int'(err_len), 1);
        run(mk(63, 1, 0, 0, 0, 1, 0, 0), "R4");
        check(!err_len, "R10", "err_len cleared by go", int'(err_len), 0);
        check(flen[b] == 65, "R4", "full buffer frame", flen[b], 65);
        check(fb[b][1] == 8'h3C && fb[b][64] == (8'd63 ^ 8'h3C), "R4", "first/last data",
              int'({fb[b][1], fb[b][64]}), int'({8'h3C, 8'd63 ^ 8'h3C}));

        // T7 poll timeout (R8)
        wreg(SEL_POLL, 32'd3);
        busy_until = npoll + 1000;
        b = nfr;
        run(mk(0, 0, 0, 1, 0, 1, 0, 0), "R8");
        check(err_timeout == 1'b1, "R8", "err_timeout", int'(err_timeout), 1);
        check(nfr - b == 5, "R8", "frames before timeout", nfr - b, 5);
        repeat (10) @(negedge clk);
        check(spi_cs_n && nfr - b == 5, "R8", "cs released, no more frames", nfr - b, 5);
        check(err_timeout == 1'b1, "R10", "err_timeout held", int'(err_timeout), 1);

        // T8 lock freezes prefix and slots (R7)
        wreg(SEL_POLL, 32'd8);
        busy_until = npoll;
        wreg(SEL_CTRL, mk(0, 0, 0, 0, 0, 0, 0, 1));
        wreg(SEL_PREFIX, 32'h0000_AAAA);
        wreg(SEL_MENU, 32'hFFFF_FFFF);
        b = nfr;
        run(mk(0, 0, 0, 1, 0, 1, 0, 0), "R7");
        check(fb[b][0] == 8'h06, "R7", "prefix after lock", int'(fb[b][0]), 8'h06);
        check(fb[b+1][0] == 8'h02, "R7", "slot after lock", int'(fb[b+1][0]), 8'h02);
        check(!err_timeout, "R10", "err_timeout cleared by go", int'(err_timeout), 0);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule